// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block produces one pulse-width-modulated output from a single counter and a single compare channel. A period value sets how many counter steps make up one PWM cycle. A compare value sets how many of those steps the output spends active. The counter advances only on clock cycles where a clock-enable tick input is high, so the PWM rate can be scaled without touching the period.

Software writes four word locations through a one-cycle write port: control, period, compare and command. The period and compare values can each be held in a buffer register. A buffered value moves into the active register only on an update event, so a new duty cycle or period never splits a PWM cycle. The counter raises an update event when it wraps. A command bit forces one at once, which loads the buffers and restarts the counter. Each update event is reported on a one-cycle output pulse.

The counter runs in one of three ways: edge-aligned counting up, edge-aligned counting down, or center-aligned counting up and down. The compare test follows the current direction. Two PWM mode codes give opposite reference levels, and the output has a polarity bit and an enable bit.

Top module: `pwm_timer_channel`

## Requirements
- R1: Writes set a location chosen by `wr_addr`: 0 = control, 1 = period, 2 = compare, 3 = command (bit 0 set forces an update). Control bits are: [2:0] mode, [3] compare buffer enable, [4] period buffer enable, [5] count down, [7:6] alignment (00 edge-aligned, any other value center-aligned), [8] invert output, [9] output enable, [10] run. After reset all values are 0, `pwm_out` is 0 and `update_pulse` is 0.
- R2: With mode code 110, the reference is high while the counter is below the active compare value when counting up, and while the counter is at or below the compare value when counting down.
- R3: Mode code 111 gives the inverse of the mode-110 reference for the same counter and compare values. Every other mode code holds the reference low.
- R4: In edge-aligned up-counting with mode 110, a compare value of 0 keeps the reference low for the whole period. A compare value of period+1 or more keeps it high for the whole period.
- R5: When the output enable is 0, `pwm_out` is 0. When it is 1, `pwm_out` equals the reference, inverted if the invert bit is set.
- R6: In edge-aligned up-counting the counter goes from 0 to the period value, then returns to 0 with an update event, so one PWM cycle is period+1 ticks. `update_pulse` is high for one clock in the cycle after each update event.
- R7: In edge-aligned down-counting the counter goes from the period value down to 0, then reloads the period value with an update event.
- R8: In center-aligned mode the counter rises to the period value and then falls to 0, with an update event at each turning point, so there are `period` ticks between update events. The value at the top counts as falling and 0 counts as rising, which makes the duty symmetric: with mode 110 the output is active for 2·min(compare, period) of every 2·period ticks.
- R9: With compare buffering enabled, a compare write leaves the active compare unchanged until the next update event. With buffering disabled, the write takes effect on the next clock.
- R10: With period buffering enabled, a new period takes effect only at the next update event. With buffering disabled, it takes effect on the next clock.
- R11: A forced update loads both buffers into the active registers and restarts the counter: at 0 counting up for up-counting and center-aligned modes, or at the new period value for down-counting. `update_pulse` follows on the next clock. This works whether or not the run bit is set.
- R12: The counter holds its value on any clock where `tick` is low or the run bit is clear, unless a forced update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Location selected for the write |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM output after polarity and enable |
| update_pulse | output | 1 | One-cycle pulse after each update event |

## Verification
The bench goes after the compare limits. A compare value of 0 must give no active cycles and a value at or above period+1 a fully active cycle; a comparison off by one would leak or lose a single cycle per period. It changes buffered compare and period values while the counter is stopped or mid-cycle. A design that writes straight through would change the duty or the update spacing too early, and one that never loads the buffers would ignore a forced update. It measures the spacing of update events in down-counting and center-aligned modes and at half tick rate, which exposes a wrong reload value, a doubled turning point or a counter that ignores the tick.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int CTRL_W = 11;

    localparam logic [1:0] LOC_CTRL   = 2'd0;
    localparam logic [1:0] LOC_PERIOD = 2'd1;
    localparam logic [1:0] LOC_CMP    = 2'd2;
    localparam logic [1:0] LOC_CMD    = 2'd3;

    localparam logic [2:0] MODE_PWM_A = 3'b110;
    localparam logic [2:0] MODE_PWM_B = 3'b111;

    localparam logic [1:0] ALIGN_EDGE = 2'b00;

    // Packed from MSB: field positions match the control word bits.
    typedef struct packed {
        logic       run;         // [10]
        logic       out_on;      // [9]
        logic       inv_pol;     // [8]
        logic [1:0] align;       // [7:6]
        logic       count_down;  // [5]
        logic       per_buf;     // [4]
        logic       cmp_buf;     // [3]
        logic [2:0] mode;        // [2:0]
    } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cnt_uev,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] period_act,
    output logic [CNT_W-1:0] period_buf,
    output logic [CNT_W-1:0] cmp_act,
    output logic             force_upd,
    output logic             uev
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per_pre;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] cmp_pre;
        logic [CNT_W-1:0] cmp_sh;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        force_upd = wr_en && (wr_addr == LOC_CMD) && wr_data[0];
        uev       = force_upd || cnt_uev;
        s_d       = s_q;
        if (uev) begin
            s_d.per_sh = s_q.per_pre;
            s_d.cmp_sh = s_q.cmp_pre;
        end
        if (wr_en) begin
            unique case (wr_addr)
                LOC_CTRL:   s_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                LOC_PERIOD: begin
                    s_d.per_pre = wr_data;
                    if (!s_q.ctrl.per_buf) s_d.per_sh = wr_data;
                end
                LOC_CMP: begin
                    s_d.cmp_pre = wr_data;
                    if (!s_q.ctrl.cmp_buf) s_d.cmp_sh = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl       = s_q.ctrl;
    assign period_act = s_q.per_sh;
    assign period_buf = s_q.per_pre;
    assign cmp_act    = s_q.cmp_sh;

    // R9: buffered compare holds between update events
    a_r9_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.cmp_buf && !uev) |=> $stable(s_q.cmp_sh));

    // R10: buffered period holds between update events
    a_r10_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.per_buf && !uev) |=> $stable(s_q.per_sh));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period_act,
    input  logic [CNT_W-1:0] period_buf,
    input  logic             force_upd,
    output logic [CNT_W-1:0] count,
    output logic             falling,
    output logic             cnt_uev
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_t;

    cnt_t c_d, c_q;
    logic           step;
    logic           edge_mode;
    logic [CNT_W:0] inc_w;

    always_comb begin
        step      = tick && ctrl.run;
        edge_mode = (ctrl.align == ALIGN_EDGE);
        inc_w     = {1'b0, c_q.cnt} + 1'b1;
        c_d       = c_q;
        cnt_uev   = 1'b0;
        if (force_upd) begin
            c_d.down = edge_mode && ctrl.count_down;
            c_d.cnt  = c_d.down ? period_buf : '0;
        end else if (step) begin
            if (edge_mode && !ctrl.count_down) begin
                c_d.down = 1'b0;
                if (c_q.cnt >= period_act) begin
                    c_d.cnt = '0;
                    cnt_uev = 1'b1;
                end else begin
                    c_d.cnt = inc_w[CNT_W-1:0];
                end
            end else if (edge_mode) begin
                c_d.down = 1'b1;
                if (c_q.cnt == '0) begin
                    c_d.cnt = period_act;
                    cnt_uev = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end else if (!c_q.down) begin
                if (inc_w >= {1'b0, period_act}) begin
                    c_d.cnt  = period_act;
                    c_d.down = 1'b1;
                    cnt_uev  = 1'b1;
                end else begin
                    c_d.cnt = inc_w[CNT_W-1:0];
                end
            end else begin
                if (c_q.cnt <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                    c_d.cnt  = '0;
                    c_d.down = 1'b0;
                    cnt_uev  = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count   = c_q.cnt;
    assign falling = edge_mode ? ctrl.count_down : c_q.down;

    // R12: no tick or no run, and no forced update: counter holds
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && ctrl.run) && !force_upd) |=> $stable(c_q.cnt));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             falling,
    output logic             pwm_out
);

    logic hit;
    logic ref_lvl;

    always_comb begin
        hit = falling ? (count <= cmp_act) : (count < cmp_act);
        unique case (ctrl.mode)
            MODE_PWM_A: ref_lvl = hit;
            MODE_PWM_B: ref_lvl = !hit;
            default:    ref_lvl = 1'b0;
        endcase
        pwm_out = ctrl.out_on && (ref_lvl ^ ctrl.inv_pol);
    end

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             update_pulse
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] period_act, period_buf, cmp_act, count;
    logic             force_upd, uev, cnt_uev, falling;
    logic             upd_d, upd_q;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_uev(cnt_uev), .ctrl(ctrl),
        .period_act(period_act), .period_buf(period_buf),
        .cmp_act(cmp_act), .force_upd(force_upd), .uev(uev)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl),
        .period_act(period_act), .period_buf(period_buf),
        .force_upd(force_upd), .count(count), .falling(falling),
        .cnt_uev(cnt_uev)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_compare (
        .ctrl(ctrl), .count(count), .cmp_act(cmp_act),
        .falling(falling), .pwm_out(pwm_out)
    );

    always_comb upd_d = uev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= upd_d;
    end

    assign update_pulse = upd_q;

    // R11: a forced update is reported on the next clock
    a_r11_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> update_pulse);

    // R5: disabled output stays low
    a_r5_out_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.out_on |-> !pwm_out);

    // R6: in edge-aligned up-counting an update leaves the counter at 0
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pulse && $stable(ctrl) && ctrl.align == ALIGN_EDGE
         && !ctrl.count_down) |-> (count == '0));

    // R7: in edge-aligned down-counting an update leaves the counter at the period
    a_r7_reload_top: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pulse && $stable(ctrl) && $stable(period_act)
         && ctrl.align == ALIGN_EDGE && ctrl.count_down) |-> (count == period_act));

endmodule

// File: tb/tb_pwm_timer_channel.sv
module tb_pwm_timer_channel;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out, update_pulse;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  half_rate = 1'b0;

    pwm_timer_channel #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .update_pulse(update_pulse)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (half_rate) tick <= ~tick;
        else           tick <= 1'b1;
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int ctrl_word(input int mode, input bit cbuf, input bit pbuf,
                                     input bit down, input int align, input bit inv,
                                     input bit on, input bit run);
        return mode | (int'(cbuf) << 3) | (int'(pbuf) << 4) | (int'(down) << 5)
             | (align << 6) | (int'(inv) << 8) | (int'(on) << 9) | (int'(run) << 10);
    endfunction

    // Ends at the negedge where the forced update is reported.
    task automatic setup(input int mode, input bit down, input int align, input bit inv,
                         input bit on, input int per, input int cmp);
        wr(2'd0, ctrl_word(mode, 0, 0, down, align, inv, on, 0));
        wr(2'd1, per);
        wr(2'd2, cmp);
        wr(2'd0, ctrl_word(mode, 0, 0, down, align, inv, on, 1));
        wr(2'd3, 1);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic gap(output int n);
        n = 0;
        for (int i = 1; i < 200; i++) begin
            @(negedge clk);
            if (update_pulse) begin n = i; break; end
        end
    endtask

    task automatic duty_case(input string req, input int mode, input bit down, input int align,
                             input bit inv, input bit on, input int per, input int cmp,
                             input int win, input int exp, input string what);
        int hi;
        setup(mode, down, align, inv, on, per, cmp);
        count_high(win, hi);
        check(req, hi, exp, what);
    endtask

    task automatic t_reset;
        check("R1", int'(pwm_out), 0, "pwm_out after reset");
        check("R1", int'(update_pulse), 0, "update_pulse after reset");
    endtask

    task automatic t_modes;
        duty_case("R2", 3'b110, 0, 0, 0, 1, 9, 3, 10, 3, "mode 110 up duty");
        duty_case("R3", 3'b111, 0, 0, 0, 1, 9, 3, 10, 7, "mode 111 up duty");
        duty_case("R3", 3'b000, 0, 0, 0, 1, 9, 3, 10, 0, "other mode code duty");
    endtask

    task automatic t_limits;
        duty_case("R4", 3'b110, 0, 0, 0, 1, 9, 0, 10, 0, "compare 0");
        duty_case("R4", 3'b110, 0, 0, 0, 1, 9, 10, 10, 10, "compare period+1");
        duty_case("R4", 3'b110, 0, 0, 0, 1, 9, 200, 10, 10, "compare far above period");
    endtask

    task automatic t_output;
        duty_case("R5", 3'b110, 0, 0, 1, 1, 9, 3, 10, 7, "inverted output duty");
        duty_case("R5", 3'b110, 0, 0, 1, 0, 9, 3, 10, 0, "disabled output duty");
    endtask

    task automatic t_edge_up;
        int n;
        setup(3'b110, 0, 0, 0, 1, 9, 3);
        gap(n);
        check("R6", n, 10, "up-count update spacing");
        gap(n);
        check("R6", n, 10, "up-count update spacing again");
        @(negedge clk);
        check("R6", int'(update_pulse), 0, "pulse lasts one clock");
    endtask

    task automatic t_edge_down;
        int n;
        duty_case("R7", 3'b110, 1, 0, 0, 1, 9, 3, 10, 4, "down-count duty");
        gap(n);
        check("R7", n, 1, "reload right after window");
        gap(n);
        check("R7", n, 10, "down-count update spacing");
    endtask

    task automatic t_center;
        int n;
        duty_case("R8", 3'b110, 0, 1, 0, 1, 6, 2, 12, 4, "center duty");
        setup(3'b110, 0, 2, 0, 1, 6, 2);
        gap(n);
        check("R8", n, 6, "center update spacing up");
        gap(n);
        check("R8", n, 6, "center update spacing down");
    endtask

    task automatic t_cmp_buffer;
        wr(2'd0, ctrl_word(3'b110, 0, 0, 0, 0, 0, 1, 0));
        wr(2'd1, 9);
        wr(2'd2, 0);
        wr(2'd3, 1);
        check("R11", int'(update_pulse), 1, "forced update pulse while stopped");
        check("R9", int'(pwm_out), 0, "compare 0 at count 0");
        wr(2'd0, ctrl_word(3'b110, 1, 0, 0, 0, 0, 1, 0));
        wr(2'd2, 5);
        @(negedge clk);
        check("R9", int'(pwm_out), 0, "buffered compare not yet active");
        wr(2'd3, 1);
        check("R11", int'(pwm_out), 1, "forced update loads compare");
        wr(2'd0, ctrl_word(3'b110, 0, 0, 0, 0, 0, 1, 0));
        wr(2'd2, 0);
        check("R9", int'(pwm_out), 0, "unbuffered compare immediate");
    endtask

    task automatic t_per_buffer;
        int n;
        setup(3'b110, 0, 0, 0, 1, 9, 3);
        wr(2'd0, ctrl_word(3'b110, 0, 1, 0, 0, 0, 1, 1));
        gap(n);
        wr(2'd1, 4);
        gap(n);
        check("R10", n, 9, "buffered period waits for update");
        gap(n);
        check("R10", n, 5, "buffered period after update");
        wr(2'd0, ctrl_word(3'b110, 0, 0, 0, 0, 0, 1, 1));
        wr(2'd1, 9);
        gap(n);
        wr(2'd1, 4);
        gap(n);
        check("R10", n, 4, "unbuffered period immediate");
    endtask

    task automatic t_force_down;
        int hi;
        wr(2'd0, ctrl_word(3'b110, 0, 0, 1, 0, 0, 1, 0));
        wr(2'd1, 7);
        wr(2'd2, 9);
        wr(2'd0, ctrl_word(3'b110, 0, 1, 1, 0, 0, 1, 0));
        wr(2'd1, 3);
        wr(2'd2, 2);
        check("R12", int'(pwm_out), 1, "stopped counter holds level");
        wr(2'd3, 1);
        check("R11", int'(pwm_out), 0, "forced down restart at new period");
        repeat (3) @(negedge clk);
        check("R12", int'(pwm_out), 0, "no run bit, counter stays");
        wr(2'd0, ctrl_word(3'b110, 0, 1, 1, 0, 0, 1, 1));
        count_high(4, hi);
        check("R11", hi, 3, "down count 3..0 after restart");
    endtask

    task automatic t_tick;
        int n;
        setup(3'b110, 0, 0, 0, 1, 9, 3);
        half_rate = 1'b1;
        gap(n);
        gap(n);
        check("R12", n, 20, "half tick rate doubles period");
        half_rate = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_modes();
        t_limits();
        t_output();
        t_edge_up();
        t_edge_down();
        t_center();
        t_cmp_buffer();
        t_per_buffer();
        t_force_down();
        t_tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule